// File: doc/BRIEF.md
# Gradient Orientation Quantizer

This stage sits in a streaming feature-extraction pipeline, directly after the luminance neighbourhood logic. Each transfer carries one pixel's signed horizontal difference `dx` and vertical difference `dy`. The stage returns two results for that pixel. The first is a 3-bit orientation label, which picks one of eight bins over a half-turn. The second is the gradient magnitude, floor(sqrt(dx² + dy²)). The label comes from sign agreement plus scaled-integer comparisons of `1024·|dy|` against `|dx|` times the constants 5148, 1533, 684 and 204. No arctangent and no divider are used. The magnitude comes from a digit-by-digit integer square root built inside the block.

Both sides are valid/ready streams. A transfer happens on a rising edge where valid and ready are both high. The pipeline is two registers deep and moves as one unit. It advances whenever the output register is empty or the output is being taken. As a result, `in_ready` equals `!out_valid || out_ready`, and it follows `out_ready` combinationally. While the output is stalled, the output stays frozen and no new input is accepted. Inputs are expected in the range −255…+255, which is the difference of two 8-bit luminance values.

Top module: `grad_orient_quant`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When `out_ready` stays high, a pair accepted on edge n is presented with `out_valid` high after edge n+1. The total latency is two edges.
- R3: When dx and dy have the same sign, the label is chosen by the first test that holds, in this order:
  - 0 if 5148·|dx| ≤ 1024·|dy|;
  - 1 if 1533·|dx| ≤ 1024·|dy|;
  - 2 if 684·|dx| ≤ 1024·|dy|;
  - 3 if 204·|dx| ≤ 1024·|dy|;
  - 4 otherwise.
- R4: When the signs differ, the same ordered tests give the labels 0, 7, 6, 5 and 4.
- R5: A zero difference counts as non-negative. The pair (0, 0) gives label 4 and magnitude 0. The pair (0, dy≠0) gives label 0. The pair (dx≠0, 0) gives label 4.
- R6: Negating both dx and dy leaves the label and the magnitude unchanged.
- R7: The magnitude is the truncated integer square root of dx² + dy². For (±255, ±255) it is 360.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is 0, and `out_label` and `out_mag` hold their values.
- R9: Items leave in acceptance order, each exactly once. `out_valid` drops once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Difference pair is present |
| in_ready | output | 1 | Stage can take a pair this cycle |
| in_dx | input | 9 | Signed horizontal difference |
| in_dy | input | 9 | Signed vertical difference |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_label | output | 3 | Orientation bin 0…7 |
| out_mag | output | 9 | Truncated gradient magnitude |

## Verification
The bench targets pairs that sit one step either side of a threshold, such as (1,5) against (1,6) and (5,1) against (6,1). A design with a wrong constant or with `<` in place of `≤` would put these pairs in the neighbouring bin. Opposite-sign pairs and negated pairs check the sign mirroring. A design that mapped the mirrored bins wrongly would return 1–3 where 7–5 is expected. Axis and zero pairs check the zero-sign rule. A naive comparison chain would label (0,0) as 0. The (±255, ±255) pairs check the magnitude width limit. A stall of several cycles with a third item waiting checks that nothing is lost or duplicated and that the held output does not change.

// File: rtl/grad_oq_pkg.sv
package grad_oq_pkg;
  // Scaled tangents of the bin edges, fixed point with FRAC_BITS fraction bits
  localparam int FRAC_BITS   = 10;
  localparam int TAN_STEEP   = 5148;
  localparam int TAN_UPPER   = 1533;
  localparam int TAN_MID     = 684;
  localparam int TAN_SHALLOW = 204;
  localparam int CONST_W     = 13;   // bits to hold the largest constant

  typedef logic [2:0] orient_t;
  localparam orient_t ORIENT_VERT = 3'd0;
  localparam orient_t ORIENT_FLAT = 3'd4;
endpackage

// File: rtl/grad_prep.sv
module grad_prep #(
  parameter int DIFF_W = 9,
  localparam int SQ_W  = 2 * DIFF_W
) (
  input  logic signed [DIFF_W-1:0] dx,
  input  logic signed [DIFF_W-1:0] dy,
  output logic        [DIFF_W-1:0] abs_x,
  output logic        [DIFF_W-1:0] abs_y,
  output logic                     agree,
  output logic        [SQ_W-1:0]   sum_sq
);
  logic [SQ_W-1:0] sq_x, sq_y;

  // zero is treated as non-negative, so only the sign bits are compared
  assign agree = (dx[DIFF_W-1] == dy[DIFF_W-1]);
  assign abs_x = dx[DIFF_W-1] ? DIFF_W'(-dx) : DIFF_W'(dx);
  assign abs_y = dy[DIFF_W-1] ? DIFF_W'(-dy) : DIFF_W'(dy);

  assign sq_x   = SQ_W'(abs_x) * SQ_W'(abs_x);
  assign sq_y   = SQ_W'(abs_y) * SQ_W'(abs_y);
  assign sum_sq = sq_x + sq_y;
endmodule

// File: rtl/grad_bin.sv
module grad_bin
  import grad_oq_pkg::*;
#(
  parameter int DIFF_W = 9,
  localparam int PROD_W = DIFF_W + CONST_W
) (
  input  logic [DIFF_W-1:0] abs_x,
  input  logic [DIFF_W-1:0] abs_y,
  input  logic              agree,
  output orient_t           label
);
  logic [PROD_W-1:0] lhs_y, rhs_steep, rhs_upper, rhs_mid, rhs_shallow;

  assign lhs_y       = PROD_W'(abs_y) << FRAC_BITS;
  assign rhs_steep   = PROD_W'(abs_x) * PROD_W'(TAN_STEEP);
  assign rhs_upper   = PROD_W'(abs_x) * PROD_W'(TAN_UPPER);
  assign rhs_mid     = PROD_W'(abs_x) * PROD_W'(TAN_MID);
  assign rhs_shallow = PROD_W'(abs_x) * PROD_W'(TAN_SHALLOW);

  always_comb begin
    if (abs_x == '0 && abs_y == '0)   label = ORIENT_FLAT;
    else if (rhs_steep   <= lhs_y)    label = ORIENT_VERT;
    else if (rhs_upper   <= lhs_y)    label = agree ? 3'd1 : 3'd7;
    else if (rhs_mid     <= lhs_y)    label = agree ? 3'd2 : 3'd6;
    else if (rhs_shallow <= lhs_y)    label = agree ? 3'd3 : 3'd5;
    else                              label = ORIENT_FLAT;
  end
endmodule

// File: rtl/grad_isqrt.sv
module grad_isqrt #(
  parameter int ROOT_W = 9,
  localparam int RAD_W = 2 * ROOT_W,
  localparam int REM_W = ROOT_W + 3,
  localparam int CHK_W = RAD_W + 2
) (
  input  logic [RAD_W-1:0]  radicand,
  output logic [ROOT_W-1:0] root
);
  logic [REM_W-1:0]  rem_q  [ROOT_W+1];
  logic [ROOT_W-1:0] root_q [ROOT_W+1];

  assign rem_q[0]  = '0;
  assign root_q[0] = '0;

  // one result bit per step, two radicand bits consumed per step
  for (genvar s = 0; s < ROOT_W; s++) begin : g_step
    localparam int J = ROOT_W - 1 - s;
    logic [REM_W-1:0] shifted, trial;
    logic             fits;
    assign shifted = (rem_q[s] << 2) | REM_W'(radicand[2*J+1 -: 2]);
    assign trial   = REM_W'({root_q[s], 2'b01});
    assign fits    = (shifted >= trial);
    assign rem_q[s+1]  = fits ? (shifted - trial) : shifted;
    assign root_q[s+1] = {root_q[s][ROOT_W-2:0], fits};
  end

  assign root = root_q[ROOT_W];

  logic [CHK_W-1:0] lo_sq, hi_sq, rad_ext;
  assign rad_ext = CHK_W'(radicand);
  assign lo_sq   = CHK_W'(root) * CHK_W'(root);
  assign hi_sq   = (CHK_W'(root) + 1'b1) * (CHK_W'(root) + 1'b1);

  always_comb begin
    AST_SQRT_BRACKET: assert (lo_sq <= rad_ext && hi_sq > rad_ext &&
                              CHK_W'(rem_q[ROOT_W]) == rad_ext - lo_sq)
      else $error("root %0d does not bracket %0d", root, radicand); // R7
  end
endmodule

// File: rtl/grad_orient_quant.sv
module grad_orient_quant
  import grad_oq_pkg::*;
#(
  parameter int LUM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [LUM_W:0] in_dx,
  input  logic signed [LUM_W:0] in_dy,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2:0]           out_label,
  output logic [LUM_W:0]       out_mag
);
  localparam int DIFF_W  = LUM_W + 1;
  localparam int SQ_W    = 2 * DIFF_W;
  localparam int MAG_CAP = ((1 << LUM_W) * 1449) >> 10;  // ~ 2^LUM_W * sqrt(2)

  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // stage 1: absolute values, sign agreement, sum of squares
  logic [DIFF_W-1:0] c_ax, c_ay;
  logic              c_agree;
  logic [SQ_W-1:0]   c_sq;

  grad_prep #(.DIFF_W(DIFF_W)) i_prep (
    .dx(in_dx), .dy(in_dy), .abs_x(c_ax), .abs_y(c_ay),
    .agree(c_agree), .sum_sq(c_sq)
  );

  logic              s1_vld;
  logic [DIFF_W-1:0] s1_ax, s1_ay;
  logic              s1_agree;
  logic [SQ_W-1:0]   s1_sq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
    end else if (advance) begin
      s1_vld <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && in_valid) begin
      s1_ax    <= c_ax;
      s1_ay    <= c_ay;
      s1_agree <= c_agree;
      s1_sq    <= c_sq;
    end
  end

  // stage 2: bin selection and square root
  orient_t           c_label;
  logic [DIFF_W-1:0] c_mag;

  grad_bin #(.DIFF_W(DIFF_W)) i_bin (
    .abs_x(s1_ax), .abs_y(s1_ay), .agree(s1_agree), .label(c_label)
  );

  grad_isqrt #(.ROOT_W(DIFF_W)) i_isqrt (
    .radicand(s1_sq), .root(c_mag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && s1_vld) begin
      out_label <= c_label;
      out_mag   <= c_mag;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_label) && $stable(out_mag))); // R8
  AST_BLOCK_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid); // R2
  AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_mag) <= MAG_CAP)); // R7
  AST_ZERO_PAIR_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mag == '0) |-> (out_label == ORIENT_FLAT)); // R5
endmodule

// File: tb/test_grad_orient_quant.sv
module test_grad_orient_quant;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [8:0] in_dx = '0;
  logic signed [8:0] in_dy = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [2:0] out_label;
  logic [8:0] out_mag;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  grad_orient_quant i_grad_orient_quant (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dx(in_dx), .in_dy(in_dy), .out_valid(out_valid), .out_ready(out_ready),
    .out_label(out_label), .out_mag(out_mag)
  );

  localparam int N = 24;
  // dx, dy, expected label, expected magnitude
  localparam int TDX [N] = '{ 40, 40, 40, 40, 40,  40, -40,  40, -40, 40,
                             -40, -40,  1,  1,  5,   6,   3,   2,   0, -9,
                               0, 255, -255, -3};
  localparam int TDY [N] = '{250, 100, 40, 20,  5, -250, 100, -40,  20, -5,
                             -100, -20,  5,  6,  1,   1,   2,   3,  -7,  0,
                               0, 255, 255,  4};
  localparam int TLB [N] = '{  0,   1,  2,  3,  4,   0,   7,   6,   5,  4,
                               1,   3,  1,  0,  3,   4,   3,   1,   0,  4,
                               4,   2,  6,  6};
  localparam int TMG [N] = '{253, 107, 56, 44, 40, 253, 107,  56,  44, 40,
                             107,  44,  5,  6,  5,   6,   3,   3,   7,  9,
                               0, 360, 360,  5};
  localparam string TRQ [N] = '{"R3", "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R4", "R4",
                                "R6", "R6", "R3", "R3", "R3", "R3", "R3", "R3", "R5", "R5",
                                "R5", "R7", "R7", "R4"};

  task automatic expect_out(input string req, input int el, input int em);
    n_total++;
    if (out_valid !== 1'b1 || out_label !== 3'(el) || out_mag !== 9'(em)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b label=%0d mag=%0d, expected valid=1 label=%0d mag=%0d",
               req, out_valid, out_label, out_mag, el, em);
    end
  endtask

  task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s=%0b, expected %0b", req, what, act, exp);
    end
  endtask

  task automatic drive(input int dx, input int dy);
    in_valid = 1'b1;
    in_dx    = 9'(dx);
    in_dy    = 9'(dy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_bit("R1", "out_valid", out_valid, 1'b0);
    expect_bit("R1", "in_ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bit("R1", "out_valid after release", out_valid, 1'b0);

    // table walk, back to back; result of vector k seen two negedges later (R2)
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk);
      if (k >= 2) expect_out({TRQ[k-2], "/R2"}, TLB[k-2], TMG[k-2]);
      if (k < N) drive(TDX[k], TDY[k]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    expect_bit("R9", "out_valid after drain", out_valid, 1'b0);

    // R8: stall with a third item waiting
    out_ready = 1'b0;
    drive(40, 100);                      // A: label 1, mag 107
    @(negedge clk);
    drive(-40, 20);                      // B: label 5, mag 44
    @(negedge clk);
    drive(0, -7);                        // C: label 0, mag 7
    expect_out("R8", 1, 107);
    expect_bit("R8", "in_ready", in_ready, 1'b0);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      expect_out("R8", 1, 107);
      expect_bit("R8", "in_ready", in_ready, 1'b0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R9", 5, 44);
    @(negedge clk);
    expect_out("R9", 0, 7);
    @(negedge clk);
    expect_bit("R9", "out_valid after stall drain", out_valid, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule